// File: doc/BRIEF.md
# Dual Down-Counting Interval Timer

This block holds two independent down-counters behind a small register window. One shared control word configures both channels. For each channel it holds an enable, an auto-reload enable, a clock-source select and a divider field. Each channel counts either on a prescaled version of the bus clock or on pulses of an external reference tick. The prescaled rate is the bus clock divided by 2^N, where N is that channel's own 3-bit divider field.

A counter expires when it decrements from zero. When it expires it sets a sticky event flag, and that flag drives an interrupt line. With auto-reload on, the counter then takes its reload value. With auto-reload off, the counter stays at zero and clears its own enable bit. This gives one-shot operation. Software clears a flag by writing zero to its bit in the status word.

Software can measure elapsed time by loading all-ones into a channel, letting it wrap freely, and reading the bitwise inverse of the counter. For a periodic interrupt every P ticks, it programs P-1 into both the reload and the value registers.

Top module: `dual_down_timer`

## Requirements
- R1: Byte offsets: control 0x00, status 0x04, channel 0 reload 0x10, channel 0 value 0x14, channel 1 reload 0x18, channel 1 value 0x1C. Read data is registered: it appears on the cycle after the address is presented, and it reflects the state before that edge. Unmapped offsets read zero. Every register resets to zero.
- R2: Control word fields: bit 0 enables channel 0 and bit 1 enables its auto-reload; bit 2 enables channel 1 and bit 3 enables its auto-reload; bit 11 selects the reference tick for channel 0 and bit 12 does so for channel 1. The channel 0 divider is bits 21:19 and the channel 1 divider is bits 24:22. All other bits read back as zero.
- R3: With the reference select clear, an enabled channel with divider N decrements once every 2^N clock cycles. The first decrement comes 2^N cycles after the edge that wrote the enable.
- R4: With the reference select set, an enabled channel decrements once on every cycle in which `ref_tick` is high. The divider field has no effect in this mode.
- R5: A decrement from zero sets the channel's event flag. With auto-reload on, the counter then loads the reload register.
- R6: With auto-reload off, an expiring counter stays at zero and its enable bit reads back as zero.
- R7: A write to a value register loads that counter at once, whether the channel is enabled or not. A disabled channel holds its value.
- R8: Status bit 0 is the channel 0 flag and bit 8 is the channel 1 flag. Writing 0 to a flag bit clears it and writing 1 leaves it unchanged. If an expiry and a clearing write land in the same cycle, the flag stays set.
- R9: `irq[i]` is the registered level of channel i's event flag.
- R10: With reload and value both at 0xFFFFFFFF and auto-reload on, the bitwise inverse of the value register equals the number of ticks elapsed.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Bus and counting clock |
| rst | input | 1 | Synchronous active-high reset |
| ref_tick | input | 1 | Single-cycle fixed reference tick pulse |
| bus_wr | input | 1 | Write strobe |
| bus_addr | input | 5 | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Registered read data for `bus_addr` |
| irq | output | 2 | Per-channel interrupt level |

## Verification
The hardest case to reach from the ports is an expiry that falls in the same clock cycle as a status write that clears the flag. On the prescaled clock, that edge depends on the prescaler phase.

The stimulus avoids the phase problem. It loads zero into channel 1, selects the reference tick, and then raises `ref_tick` and the clearing write on the same negative edge. The two therefore meet at a known edge.

Random runs cover the rest. They vary the channel, the divider, the start value, the reload value, the auto-reload setting and the wait time. Every read is checked against a closed-form count of elapsed ticks, taken from the edge that wrote the enable.

// File: rtl/dtmr_pkg.sv
package dtmr_pkg;
  localparam int ADDR_W = 5;
  localparam int NUM_CH = 2;
  localparam int PSC_W  = 3;

  localparam logic [ADDR_W-1:0] OFS_CTRL = 5'h00;
  localparam logic [ADDR_W-1:0] OFS_STAT = 5'h04;
  localparam logic [ADDR_W-1:0] OFS_RLD0 = 5'h10;
  localparam logic [ADDR_W-1:0] OFS_VAL0 = 5'h14;
  localparam logic [ADDR_W-1:0] OFS_RLD1 = 5'h18;
  localparam logic [ADDR_W-1:0] OFS_VAL1 = 5'h1C;

  typedef struct packed {
    logic             run;
    logic             auto_rld;
    logic             ref_sel;
    logic [PSC_W-1:0] div;
  } ch_cfg_t;

  function automatic int pos_en(input int ch);
    return (ch == 0) ? 0 : 2;
  endfunction
  function automatic int pos_ar(input int ch);
    return (ch == 0) ? 1 : 3;
  endfunction
  function automatic int pos_ref(input int ch);
    return (ch == 0) ? 11 : 12;
  endfunction
  function automatic int pos_div(input int ch);
    return (ch == 0) ? 19 : 22;
  endfunction
  function automatic int pos_flag(input int ch);
    return (ch == 0) ? 0 : 8;
  endfunction
  function automatic logic [ADDR_W-1:0] ofs_val(input int ch);
    return (ch == 0) ? OFS_VAL0 : OFS_VAL1;
  endfunction
  function automatic logic [ADDR_W-1:0] ofs_rld(input int ch);
    return (ch == 0) ? OFS_RLD0 : OFS_RLD1;
  endfunction
endpackage

// File: rtl/dtmr_prescaler.sv
module dtmr_prescaler #(
  parameter int PSC_W = 3
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             run,
  input  logic [PSC_W-1:0] div,
  output logic             tick
);
  localparam int PC_W = (1 << PSC_W) - 1;

  logic [PC_W-1:0] pc_q;
  logic [PC_W-1:0] mask;

  always_comb begin
    for (int k = 0; k < PC_W; k++) begin
      mask[k] = (k < int'(div));
    end
  end

  always_ff @(posedge clk) begin
    if (rst || !run) pc_q <= '0;
    else             pc_q <= pc_q + PC_W'(1);
  end

  assign tick = run && ((pc_q & mask) == mask);

  // R3
  prescale_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !run |=> pc_q == '0);
endmodule

// File: rtl/dtmr_evflag.sv
module dtmr_evflag (
  input  logic clk,
  input  logic rst,
  input  logic set_i,
  input  logic clr_i,
  output logic flag_o
);
  always_ff @(posedge clk) begin
    if (rst)        flag_o <= 1'b0;
    else if (set_i) flag_o <= 1'b1;
    else if (clr_i) flag_o <= 1'b0;
  end

  // R8
  set_wins_chk: assert property (@(posedge clk) disable iff (rst)
    set_i |=> flag_o);
  // R8
  clear_works_chk: assert property (@(posedge clk) disable iff (rst)
    clr_i && !set_i |=> !flag_o);
  // R8
  flag_sticky_chk: assert property (@(posedge clk) disable iff (rst)
    flag_o && !clr_i |=> flag_o);
endmodule

// File: rtl/dtmr_channel.sv
module dtmr_channel import dtmr_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  ch_cfg_t          cfg_i,
  input  logic             ref_tick_i,
  input  logic             val_wr_i,
  input  logic             rld_wr_i,
  input  logic [CNT_W-1:0] wdata_i,
  output logic [CNT_W-1:0] cnt_o,
  output logic [CNT_W-1:0] rld_o,
  output logic             expire_o
);
  logic psc_tick;
  logic step;

  dtmr_prescaler #(.PSC_W(PSC_W)) u_psc (
    .clk  (clk),
    .rst  (rst),
    .run  (cfg_i.run),
    .div  (cfg_i.div),
    .tick (psc_tick)
  );

  assign step     = cfg_i.run && (cfg_i.ref_sel ? ref_tick_i : psc_tick);
  assign expire_o = step && !val_wr_i && (cnt_o == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_o <= '0;
    end else if (val_wr_i) begin
      cnt_o <= wdata_i;
    end else if (step) begin
      if (cnt_o != '0)         cnt_o <= cnt_o - CNT_W'(1);
      else if (cfg_i.auto_rld) cnt_o <= rld_o;
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           rld_o <= '0;
    else if (rld_wr_i) rld_o <= wdata_i;
  end

  // R7
  value_load_chk: assert property (@(posedge clk) disable iff (rst)
    val_wr_i |=> cnt_o == $past(wdata_i));
  // R7
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !cfg_i.run && !val_wr_i |=> $stable(cnt_o));
  // R5
  reload_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o && cfg_i.auto_rld |=> cnt_o == $past(rld_o));
  // R6
  oneshot_zero_chk: assert property (@(posedge clk) disable iff (rst)
    expire_o && !cfg_i.auto_rld |=> cnt_o == '0);
  // R4
  ref_gate_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_i.ref_sel && !ref_tick_i && !val_wr_i |=> $stable(cnt_o));
endmodule

// File: rtl/dual_down_timer.sv
module dual_down_timer import dtmr_pkg::*; #(
  parameter int CNT_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ref_tick,
  input  logic              bus_wr,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [CNT_W-1:0]  bus_wdata,
  output logic [CNT_W-1:0]  bus_rdata,
  output logic [NUM_CH-1:0] irq
);
  logic ctrl_wr;
  logic stat_wr;
  logic [NUM_CH-1:0] en_q;
  logic [NUM_CH-1:0] ar_q;
  logic [NUM_CH-1:0] ref_q;
  logic [NUM_CH-1:0] expire;
  logic [NUM_CH-1:0] flag;
  logic [PSC_W-1:0]  div_q [NUM_CH];
  logic [CNT_W-1:0]  cnt   [NUM_CH];
  logic [CNT_W-1:0]  rld   [NUM_CH];
  logic [CNT_W-1:0]  ctrl_word;
  logic [CNT_W-1:0]  stat_word;

  assign ctrl_wr = bus_wr && (bus_addr == OFS_CTRL);
  assign stat_wr = bus_wr && (bus_addr == OFS_STAT);

  for (genvar gi = 0; gi < NUM_CH; gi++) begin : g_ch
    localparam int EP = pos_en(gi);
    localparam int AP = pos_ar(gi);
    localparam int RP = pos_ref(gi);
    localparam int DP = pos_div(gi);
    localparam int FP = pos_flag(gi);

    logic             en_r;
    logic             ar_r;
    logic             ref_r;
    logic [PSC_W-1:0] div_r;
    ch_cfg_t          cfg;

    always_ff @(posedge clk) begin
      if (rst) begin
        en_r  <= 1'b0;
        ar_r  <= 1'b0;
        ref_r <= 1'b0;
        div_r <= '0;
      end else if (ctrl_wr) begin
        en_r  <= bus_wdata[EP];
        ar_r  <= bus_wdata[AP];
        ref_r <= bus_wdata[RP];
        div_r <= bus_wdata[DP +: PSC_W];
      end else if (expire[gi] && !ar_r) begin
        en_r  <= 1'b0;
      end
    end

    assign en_q[gi]  = en_r;
    assign ar_q[gi]  = ar_r;
    assign ref_q[gi] = ref_r;
    assign div_q[gi] = div_r;
    assign cfg       = '{run: en_r, auto_rld: ar_r, ref_sel: ref_r, div: div_r};

    dtmr_channel #(.CNT_W(CNT_W)) u_chan (
      .clk        (clk),
      .rst        (rst),
      .cfg_i      (cfg),
      .ref_tick_i (ref_tick),
      .val_wr_i   (bus_wr && (bus_addr == ofs_val(gi))),
      .rld_wr_i   (bus_wr && (bus_addr == ofs_rld(gi))),
      .wdata_i    (bus_wdata),
      .cnt_o      (cnt[gi]),
      .rld_o      (rld[gi]),
      .expire_o   (expire[gi])
    );

    dtmr_evflag u_flag (
      .clk    (clk),
      .rst    (rst),
      .set_i  (expire[gi]),
      .clr_i  (stat_wr && !bus_wdata[FP]),
      .flag_o (flag[gi])
    );

    assign irq[gi] = flag[gi];

    // R6
    oneshot_stop_chk: assert property (@(posedge clk) disable iff (rst)
      expire[gi] && !ar_r && !ctrl_wr |=> !en_r);
    // R5
    autorld_keep_chk: assert property (@(posedge clk) disable iff (rst)
      expire[gi] && ar_r && !ctrl_wr |=> en_r);
  end

  always_comb begin
    ctrl_word = '0;
    stat_word = '0;
    for (int i = 0; i < NUM_CH; i++) begin
      ctrl_word[pos_en(i)]           = en_q[i];
      ctrl_word[pos_ar(i)]           = ar_q[i];
      ctrl_word[pos_ref(i)]          = ref_q[i];
      ctrl_word[pos_div(i) +: PSC_W] = div_q[i];
      stat_word[pos_flag(i)]         = flag[i];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else begin
      case (bus_addr)
        OFS_CTRL: bus_rdata <= ctrl_word;
        OFS_STAT: bus_rdata <= stat_word;
        OFS_RLD0: bus_rdata <= rld[0];
        OFS_VAL0: bus_rdata <= cnt[0];
        OFS_RLD1: bus_rdata <= rld[1];
        OFS_VAL1: bus_rdata <= cnt[1];
        default:  bus_rdata <= '0;
      endcase
    end
  end

  // R9
  irq_follow_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(irq[0]) |-> $past(expire[0]));
endmodule

// File: tb/test_dual_down_timer.sv
`timescale 1ns/1ps
module test_dual_down_timer;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ref_tick = 1'b0;
  logic        bus_wr = 1'b0;
  logic [4:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic [1:0]  irq;

  int total = 0;
  int bad = 0;
  bit done = 0;
  longint cyc = 0;
  longint en_cyc = 0;
  longint last_wr = 0;

  dual_down_timer i_dual_down_timer (
    .clk(clk), .rst(rst), .ref_tick(ref_tick), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(posedge clk);
    #1 last_wr = cyc; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] d, output longint cap);
    @(negedge clk);
    bus_addr = a;
    @(posedge clk);
    #1 cap = cyc;
    @(negedge clk);
    d = bus_rdata;
  endtask

  task automatic pulse_ref();
    @(negedge clk); ref_tick = 1'b1;
    @(negedge clk); ref_tick = 1'b0;
  endtask

  function automatic logic [31:0] exp_val(longint v, longint r, bit ar, longint t);
    longint tt;
    if (t <= v) return 32'(v - t);
    if (!ar) return 32'h0;
    tt = t - v - 1;
    return 32'(r - (tt % (r + 1)));
  endfunction

  function automatic longint elapsed(longint cap);
    return cap - 1 - en_cyc;
  endfunction

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    longint cap, c;
    void'($urandom(32'h1234_5EED));
    repeat (4) @(posedge clk);
    #1 rst = 1'b0;

    // R1 reset state and unmapped offset
    rd(5'h00, d, cap); chk("R1 ctrl reset", d, 0);
    rd(5'h04, d, cap); chk("R1 status reset", d, 0);
    rd(5'h14, d, cap); chk("R1 val0 reset", d, 0);
    rd(5'h18, d, cap); chk("R1 rld1 reset", d, 0);
    chk("R9 irq reset", {30'd0, irq}, 0);
    wr(5'h10, 32'hABCD);
    rd(5'h08, d, cap); chk("R1 unmapped", d, 0);
    rd(5'h10, d, cap); chk("R1 rld0 readback", d, 32'hABCD);

    // R2 field readback, unused bits dropped
    wr(5'h00, 32'h40E8_180F);
    rd(5'h00, d, cap); chk("R2 ctrl fields", d, 32'h00E8_180F);
    wr(5'h00, 0);

    // R7 load while disabled, then hold
    wr(5'h14, 32'h1234);
    repeat (20) @(posedge clk);
    rd(5'h14, d, cap); chk("R7 load and hold", d, 32'h1234);

    // R3 divide-by-32
    wr(5'h14, 100);
    wr(5'h00, 32'h0028_0001); en_cyc = last_wr;
    repeat (200) @(posedge clk);
    rd(5'h14, d, cap); c = elapsed(cap);
    chk("R3 div32 count", d, exp_val(100, 0, 0, c >> 5));
    repeat (97) @(posedge clk);
    rd(5'h14, d, cap); c = elapsed(cap);
    chk("R3 div32 count later", d, exp_val(100, 0, 0, c >> 5));

    // R10 free running full range
    wr(5'h00, 0);
    wr(5'h18, 32'hFFFF_FFFF);
    wr(5'h1C, 32'hFFFF_FFFF);
    wr(5'h00, 32'h0000_000C); en_cyc = last_wr;
    repeat (333) @(posedge clk);
    rd(5'h1C, d, cap); c = elapsed(cap);
    chk("R10 inverse elapsed", ~d, 32'(c));

    // R6 one-shot expiry
    wr(5'h00, 0);
    wr(5'h04, 0);
    wr(5'h14, 10);
    wr(5'h00, 32'h1); en_cyc = last_wr;
    repeat (30) @(posedge clk);
    rd(5'h14, d, cap); chk("R6 holds zero", d, 0);
    rd(5'h00, d, cap); chk("R6 enable self-clear", d, 0);
    rd(5'h04, d, cap); chk("R5 flag set", d, 32'h1);
    chk("R9 irq high", {30'd0, irq}, 32'h1);

    // R8 write-one keeps, write-zero clears
    wr(5'h04, 32'hFFFF_FFFF);
    rd(5'h04, d, cap); chk("R8 write one keeps", d, 32'h1);
    wr(5'h04, 32'hFFFF_FFFE);
    rd(5'h04, d, cap); chk("R8 write zero clears", d, 0);
    chk("R9 irq low", {30'd0, irq}, 0);

    // R5 auto-reload, then R8 per-bit clear
    wr(5'h10, 4);
    wr(5'h14, 3);
    wr(5'h1C, 0);
    wr(5'h00, 32'h7); en_cyc = last_wr;
    repeat (17) @(posedge clk);
    rd(5'h14, d, cap); c = elapsed(cap);
    chk("R5 reload wrap", d, exp_val(3, 4, 1, c));
    rd(5'h00, d, cap); chk("R5 auto-reload stays enabled", d, 32'h3);
    wr(5'h00, 0);
    rd(5'h04, d, cap); chk("R5 both flags", d, 32'h101);
    wr(5'h04, 32'h100);
    rd(5'h04, d, cap); chk("R8 bit0 cleared bit8 kept", d, 32'h100);
    chk("R9 irq per channel", {30'd0, irq}, 32'h2);
    wr(5'h04, 0);

    // R4 reference tick, divider ignored
    wr(5'h1C, 5);
    wr(5'h00, 32'h0000_1004);
    repeat (20) @(posedge clk);
    rd(5'h1C, d, cap); chk("R4 no ref no count", d, 5);
    repeat (3) pulse_ref();
    rd(5'h1C, d, cap); chk("R4 three ref ticks", d, 2);
    repeat (3) pulse_ref();
    rd(5'h1C, d, cap); chk("R4 expired to zero", d, 0);
    rd(5'h04, d, cap); chk("R4 flag1 on expiry", d, 32'h100);
    rd(5'h00, d, cap); chk("R6 enable1 cleared", d, 32'h0000_1000);

    // R8 set wins over same-cycle clear
    wr(5'h04, 0);
    wr(5'h1C, 0);
    wr(5'h00, 32'h0000_1004);
    @(negedge clk);
    ref_tick = 1'b1; bus_wr = 1'b1; bus_addr = 5'h04; bus_wdata = 0;
    @(posedge clk);
    #1 ref_tick = 1'b0; bus_wr = 1'b0;
    rd(5'h04, d, cap); chk("R8 set wins", d, 32'h100);

    // random runs: R3 R5 R6
    for (int it = 0; it < 24; it++) begin
      int ch, n, v, r, w;
      bit ar;
      logic [31:0] cw;
      ch = $urandom % 2; n = $urandom % 4; v = $urandom % 60;
      r = $urandom % 20; ar = 1'($urandom % 2); w = $urandom % 200;
      wr(5'h00, 0);
      wr(5'h04, 0);
      wr(ch ? 5'h18 : 5'h10, r);
      wr(ch ? 5'h1C : 5'h14, v);
      cw = 0;
      cw[ch ? 2 : 0] = 1'b1;
      cw[ch ? 3 : 1] = ar;
      if (ch) cw[24:22] = 3'(n); else cw[21:19] = 3'(n);
      wr(5'h00, cw); en_cyc = last_wr;
      repeat (w) @(posedge clk);
      rd(ch ? 5'h1C : 5'h14, d, cap); c = elapsed(cap);
      chk("R3/R5 random value", d, exp_val(v, r, ar, c >> n));
      rd(5'h04, d, cap); c = elapsed(cap);
      chk("R5 random flag", d[ch ? 8 : 0], ((c >> n) > v) ? 32'h1 : 32'h0);
    end

    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule